// File: doc/BRIEF.md
# I2C Target Front End with Busy Lockout

This block is the serial front end of a small register-bank device on a two-wire bus. The system clock samples SCL and SDA. The block finds START and STOP conditions and shifts bytes in and out most significant bit first. It acknowledges its own fixed 7-bit identification, a register address byte and each byte the controller writes. On a read it returns register bytes and watches the controller's acknowledge to decide whether to continue.

Toward the register bank the block offers a plain parallel port. This port carries a byte address, write data with a one-cycle write strobe, read data that the bank returns combinationally for the presented address, and a one-cycle read strobe. The address advances by one after every data byte in either direction. A STOP that closes an accepted transaction produces a one-cycle end pulse. A qualifier on that pulse tells the bank whether any byte was written, which the bank uses to decide whether to start its persistent write cycle.

Two conditions keep the block deaf to START. The first is a fixed power-up period after reset. The second is any cycle in which the bank raises its busy input. A START that arrives under either condition is dropped, and the frame that follows gets no acknowledge. SDA is open-drain: the block only ever pulls the line low through an output enable.

Top module: `i2c_tgt_top`

## Requirements
- R1: After reset the SDA pull-down enable, the write strobe, the read strobe and the end pulse are all low.
- R2: A STOP (SDA rising while SCL is high) after an accepted START gives exactly one one-cycle end pulse. The write qualifier is high in that cycle only if at least one data byte was written since that START.
- R3: A first byte whose upper seven bits are 0101000 is acknowledged by pulling SDA low during the ninth SCL clock. Bit 0 of that byte selects read (1) or write (0). Any other first byte gets no acknowledge, and the block then ignores all bus activity until the next START.
- R4: In a write, the second byte is acknowledged and taken as the register address. Each following byte is acknowledged and presented, MSB first as received, with a one-cycle write strobe at the current address.
- R5: The register address increases by one after every data byte, whether written or read.
- R6: In a read, the block drives the byte at the current address MSB first, one bit per SCL low phase, with a read strobe when it loads each byte. It releases SDA during the ninth clock.
- R7: When the controller leaves SDA high on the ninth clock of a read byte (a NACK), the block stops sending and keeps SDA released through any further SCL clocks until the next START.
- R8: No START is accepted during the first PWRUP_CYC clock cycles after reset, so no acknowledge, write strobe or end pulse can result from it.
- R9: A START seen while the busy input is high is ignored, and the frame that follows gets no acknowledge and no end pulse.
- R10: SDA is only pulled low during acknowledge bits and read data bits, and the pull-down is only switched on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when high; released otherwise |
| busy_i | input | 1 | Register bank reports a persistent write cycle in progress |
| reg_addr_o | output | 8 | Current register address |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Byte at reg_addr_o, returned combinationally |
| reg_re_o | output | 1 | One-cycle strobe when a read byte is loaded |
| txn_end_o | output | 1 | One-cycle pulse on STOP of an accepted transaction |
| txn_wrote_o | output | 1 | With txn_end_o: at least one byte was written |

## Verification
A two-byte write followed by a repeated-START read of three bytes separates correct address latching, auto-increment and MSB-first ordering from swapped or off-by-one behaviour. Ending the read with a NACK and then clocking SCL on shows whether SDA stays released. A frame with a wrong identification, a frame sent straight after reset, and a frame sent with busy held high must each draw no acknowledge, no strobe and no end pulse. This separates the identification compare, the power-up gate and the busy gate from one another. The write qualifier on the end pulse is compared between the write frame and the read-only frame.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = 4;
    localparam logic [6:0] TGT_ID = 7'b0101000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == TGT_ID;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_i};
                    sda_q <= {sda_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_q[STAGES-1];
        ev.sda   = sda_q[STAGES-1];
        ev.start = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop  = ev.scl & scl_p & ~sda_p & ev.sda;
        ev.rise  = ev.scl & ~scl_p;
        ev.fall  = ~ev.scl & scl_p;
    end
endmodule

// File: rtl/i2c_tgt_pwrup.sv
module i2c_tgt_pwrup #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            if (cnt != LAST) cnt <= cnt + 1'b1;
            ready <= (cnt == LAST);
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              start_ok,
    input  logic [BYTE_W-1:0] rdata,
    output logic              oe,
    output logic [BYTE_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we,
    output logic              re,
    output logic              tend,
    output logic              twrote
);
    phase_t            state;
    logic [BIT_CW-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              nack;
    logic              engaged;
    logic              wrote;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            addr    <= '0;
            wdata   <= '0;
            oe      <= 1'b0;
            we      <= 1'b0;
            re      <= 1'b0;
            tend    <= 1'b0;
            twrote  <= 1'b0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            engaged <= 1'b0;
            wrote   <= 1'b0;
        end else begin
            we     <= 1'b0;
            re     <= 1'b0;
            tend   <= 1'b0;
            twrote <= 1'b0;
            if (ev.stop) begin
                if (engaged) begin
                    tend   <= 1'b1;
                    twrote <= wrote;
                end
                state   <= ST_IDLE;
                engaged <= 1'b0;
                wrote   <= 1'b0;
                oe      <= 1'b0;
            end else if (ev.start && start_ok) begin
                state   <= ST_ID;
                bitcnt  <= '0;
                engaged <= 1'b1;
                oe      <= 1'b0;
            end else begin
                unique case (state)
                    ST_ID, ST_ADDR, ST_WDATA: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == BIT_CW'(BYTE_W)) begin
                            bitcnt <= '0;
                            if (state == ST_ID) begin
                                if (id_match(shreg)) begin
                                    oe    <= 1'b1;
                                    rw    <= shreg[0];
                                    state <= ST_ID_ACK;
                                end else begin
                                    state   <= ST_IDLE;
                                    engaged <= 1'b0;
                                end
                            end else if (state == ST_ADDR) begin
                                addr  <= shreg;
                                oe    <= 1'b1;
                                state <= ST_ADDR_ACK;
                            end else begin
                                wdata <= shreg;
                                we    <= 1'b1;
                                wrote <= 1'b1;
                                oe    <= 1'b1;
                                state <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ID_ACK: begin
                        if (ev.fall) begin
                            if (rw) begin
                                shreg  <= rdata;
                                oe     <= ~rdata[BYTE_W-1];
                                re     <= 1'b1;
                                bitcnt <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                oe    <= 1'b0;
                                state <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            oe    <= 1'b0;
                            state <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (ev.fall) begin
                            oe    <= 1'b0;
                            addr  <= addr + 1'b1;
                            state <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (bitcnt == BIT_CW'(BYTE_W - 1)) begin
                                oe     <= 1'b0;
                                addr   <= addr + 1'b1;
                                bitcnt <= '0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                oe     <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            nack <= ev.sda;
                        end else if (ev.fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                shreg  <= rdata;
                                oe     <= ~rdata[BYTE_W-1];
                                re     <= 1'b1;
                                bitcnt <= '0;
                                state  <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PWRUP_CYC   = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       busy_i,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    input  logic [7:0] reg_rdata_i,
    output logic       reg_re_o,
    output logic       txn_end_o,
    output logic       txn_wrote_o
);
    bus_ev_t bus_ev;
    logic    pwr_ready;
    logic    start_ok;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    i2c_tgt_pwrup #(.CYC(PWRUP_CYC)) u_pwrup (
        .clk   (clk),
        .rst   (rst),
        .ready (pwr_ready)
    );

    assign start_ok = pwr_ready & ~busy_i;

    i2c_tgt_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .start_ok (start_ok),
        .rdata    (reg_rdata_i),
        .oe       (sda_oe_o),
        .addr     (reg_addr_o),
        .wdata    (reg_wdata_o),
        .we       (reg_we_o),
        .re       (reg_re_o),
        .tend     (txn_end_o),
        .twrote   (txn_wrote_o)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic pwr_ready,
    input logic sda_oe_o,
    input logic reg_we_o,
    input logic reg_re_o,
    input logic txn_end_o,
    input logic txn_wrote_o
);
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);                                        // R4
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        txn_end_o |=> !txn_end_o);                                      // R2
    AST_WROTE_WITH_END: assert property (@(posedge clk) disable iff (rst)
        txn_wrote_o |-> txn_end_o);                                     // R2
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_we_o && reg_re_o));                                       // R6
    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_s);                                    // R10
    AST_QUIET_IN_PWRUP: assert property (@(posedge clk) disable iff (rst)
        !pwr_ready |-> (!sda_oe_o && !reg_we_o && !txn_end_o));         // R8
endmodule

bind i2c_tgt_top i2c_tgt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (bus_ev.scl),
    .pwr_ready   (pwr_ready),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .txn_end_o   (txn_end_o),
    .txn_wrote_o (txn_wrote_o)
);

// File: tb/i2c_tgt_top_tb_top.sv
module i2c_tgt_top_tb_top;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       reg_re;
    logic       txn_end;
    logic       txn_wrote;

    logic [7:0] bank [256];
    int         end_cnt = 0;
    logic       last_wrote = 1'b0;
    int         we_cnt = 0;
    int         oe_cycles = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_tgt_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .busy_i      (busy),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata),
        .reg_re_o    (reg_re),
        .txn_end_o   (txn_end),
        .txn_wrote_o (txn_wrote)
    );

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bank[i] <= 8'(i * 7 + 3);
        end else begin
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (txn_end) begin
                end_cnt    <= end_cnt + 1;
                last_wrote <= txn_wrote;
            end
            if (sda_oe) oe_cycles <= oe_cycles + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = ~sda_line;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq();
            scl_m = 1'b0; wq();
        end
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
        chk(reg_we == 1'b0 && reg_re == 1'b0, "R1", int'({reg_we, reg_re}), 0);
        chk(txn_end == 1'b0, "R1", int'(txn_end), 0);
    endtask

    task automatic t_pwrup();
        bit a;
        int e0 = end_cnt;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'h50, a);
        chk(!a, "R8 no ack in power-up", int'(a), 0);
        send_byte(8'h20, a);
        send_byte(8'h11, a);
        bus_stop();
        chk(end_cnt == e0, "R8 no end pulse", end_cnt, e0);
        chk(we_cnt == w0, "R8 no write", we_cnt, w0);
    endtask

    task automatic t_write();
        bit a;
        int e0 = end_cnt;
        bus_start();
        send_byte(8'h50, a);
        chk(a, "R3 id ack", int'(a), 1);
        send_byte(8'h10, a);
        chk(a, "R4 addr ack", int'(a), 1);
        send_byte(8'hA5, a);
        chk(a, "R4 data ack", int'(a), 1);
        send_byte(8'h3C, a);
        chk(a, "R4 data2 ack", int'(a), 1);
        bus_stop();
        chk(bank[8'h10] == 8'hA5, "R4 write data", int'(bank[8'h10]), 'hA5);
        chk(bank[8'h11] == 8'h3C, "R5 increment write", int'(bank[8'h11]), 'h3C);
        chk(end_cnt == e0 + 1, "R2 one end pulse", end_cnt, e0 + 1);
        chk(last_wrote == 1'b1, "R2 wrote qualifier", int'(last_wrote), 1);
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        int e0 = end_cnt;
        int o0;
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h10, a);
        chk(a, "R4 addr ack before read", int'(a), 1);
        bus_start();
        send_byte(8'h51, a);
        chk(a, "R3 read id ack", int'(a), 1);
        recv_byte(b, 1'b1);
        chk(b == 8'hA5, "R6 read byte", int'(b), 'hA5);
        recv_byte(b, 1'b1);
        chk(b == 8'h3C, "R5 increment read", int'(b), 'h3C);
        recv_byte(b, 1'b0);
        chk(b == 8'h81, "R5 third read", int'(b), 'h81);
        wq();
        chk(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);
        o0 = oe_cycles;
        recv_byte(b, 1'b0);
        chk(oe_cycles == o0, "R7 silent after nack", oe_cycles, o0);
        chk(b == 8'hFF, "R7 line high after nack", int'(b), 'hFF);
        bus_stop();
        chk(end_cnt == e0 + 1, "R2 end after read", end_cnt, e0 + 1);
        chk(last_wrote == 1'b0, "R2 no write qualifier", int'(last_wrote), 0);
    endtask

    task automatic t_bad_id();
        bit a;
        int e0 = end_cnt;
        int w0 = we_cnt;
        int o0 = oe_cycles;
        bus_start();
        send_byte(8'h52, a);
        chk(!a, "R3 wrong id no ack", int'(a), 0);
        send_byte(8'h10, a);
        chk(!a, "R3 ignored after wrong id", int'(a), 0);
        send_byte(8'hFF, a);
        bus_stop();
        chk(we_cnt == w0, "R3 no write", we_cnt, w0);
        chk(end_cnt == e0, "R3 no end pulse", end_cnt, e0);
        chk(oe_cycles == o0, "R10 no pull on wrong id", oe_cycles, o0);
    endtask

    task automatic t_busy();
        bit a;
        int e0 = end_cnt;
        int o0 = oe_cycles;
        busy = 1'b1;
        bus_start();
        send_byte(8'h50, a);
        chk(!a, "R9 no ack while busy", int'(a), 0);
        send_byte(8'h30, a);
        send_byte(8'h77, a);
        bus_stop();
        busy = 1'b0;
        chk(end_cnt == e0, "R9 no end pulse", end_cnt, e0);
        chk(bank[8'h30] == 8'h53, "R9 no write", int'(bank[8'h30]), 'h53);
        chk(oe_cycles == o0, "R10 no pull while busy", oe_cycles, o0);
        bus_start();
        send_byte(8'h50, a);
        chk(a, "R9 ack after busy drops", int'(a), 1);
        send_byte(8'h30, a);
        send_byte(8'h77, a);
        bus_stop();
        chk(bank[8'h30] == 8'h77, "R9 write after busy", int'(bank[8'h30]), 'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pwrup();
        repeat (200) @(negedge clk);
        t_write();
        t_read();
        t_bad_id();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule